// File: doc/BRIEF.md
# Processor-Memory Crossbar Switch Matrix

This block is a single-level 3 x 3 crossbar joining three processor buses to three shared memory module buses. Each path carries a 16-bit address, an 8-bit data path and separate read and write strobes. Each of the nine processor/module pairs has its own crosspoint, and each crosspoint is closed by one select bit. A supervising master sets the select bits through a small control port. The bidirectional data lines are modelled as separate buses in each direction. The read and write strobes act as the direction enables.

Three processors can each hold a different module and run independent transfers at the same time. One processor may also close several crosspoints at once. A write then lands in every module it holds, which copies data into modules that share an address range. When more than one processor is closed onto the same module, the lowest-numbered one drives that module and a conflict flag is raised for it. When a processor reads from several modules, it receives the bitwise AND of their data, which models a wired-AND bus. A processor with nothing to read from sees all ones.

Top module: `xbar_matrix`

## Requirements
- R1: After reset every crosspoint is open. All memory strobes are 0, all memory addresses and memory write data are 0, every processor read bus is 0xFF, and no conflict flag is set.
- R2: Select bit k = p*3 + m closes the crosspoint from processor p to module m. A pulse on the low-byte write enable loads bits 7:0 from the byte input at the next rising edge and leaves bit 8 unchanged. A pulse on the high write enable loads bit 8 and leaves bits 7:0 unchanged. With neither enable set, the select bits hold.
- R3: When processor p drives module m, the module's address, read strobe, write strobe and write data equal processor p's values in the same cycle.
- R4: A module with no closed crosspoint sees read = 0, write = 0, address = 0 and write data = 0.
- R5: A processor holding several modules has its write strobe, address and data copied to every module it drives.
- R6: When two or more processors are closed onto module m, the lowest-numbered of them drives it and conflict flag bit m is 1. Otherwise bit m is 0.
- R7: A processor's read bus is the bitwise AND of the read data of the modules it drives. It is 0xFF when it drives none, including when it has lost every conflict.
- R8: With a one-to-one setting, the three paths carry different, simultaneous transfers without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoWe | input | 1 | Load select bits 7:0 |
| cfgLoData | input | 8 | Value for select bits 7:0 |
| cfgHiWe | input | 1 | Load select bit 8 |
| cfgHiData | input | 1 | Value for select bit 8 |
| procAddr | input | 48 | Processor addresses, processor p at [p*16 +: 16] |
| procRd | input | 3 | Processor read strobes |
| procWr | input | 3 | Processor write strobes |
| procWrData | input | 24 | Processor write data, processor p at [p*8 +: 8] |
| procRdData | output | 24 | Data returned to each processor |
| memAddr | output | 48 | Module addresses, module m at [m*16 +: 16] |
| memRd | output | 3 | Module read strobes |
| memWr | output | 3 | Module write strobes |
| memWrData | output | 24 | Module write data |
| memRdData | input | 24 | Module read data, module m at [m*8 +: 8] |
| memConflict | output | 3 | Per-module multiple-driver flag |

## Verification
The bench builds the block with the default 16-bit address and 8-bit data widths, over the fixed three-by-three matrix. With these values a nine-bit select word covers the whole space: an 8-bit write plus a separate single bit. Random settings reach every mix of fan-out, conflict and open module. Directed cases pin down the low/high write split, the priority when three processors contend, and the wired-AND read across two modules.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NUM_PROC = 3;
  localparam int NUM_MEM  = 3;
  localparam int SEL_W    = NUM_PROC * NUM_MEM;
  localparam int CFG_LO_W = 8;
  localparam int CFG_HI_W = SEL_W - CFG_LO_W;

  // Control-to-datapath strobes: crosspoint closures and resolved drivers.
  typedef struct packed {
    logic [SEL_W-1:0]   sel;
    logic [SEL_W-1:0]   grant;
    logic [NUM_MEM-1:0] conflict;
  } route_t;
endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgLoWe,
  input  logic [CFG_LO_W-1:0] cfgLoData,
  input  logic                cfgHiWe,
  input  logic [CFG_HI_W-1:0] cfgHiData,
  output route_t              route
);
  logic [SEL_W-1:0]   selQ;
  logic [SEL_W-1:0]   grantC;
  logic [NUM_MEM-1:0] conflictC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
    end else begin
      if (cfgLoWe) selQ[CFG_LO_W-1:0]     <= cfgLoData;
      if (cfgHiWe) selQ[SEL_W-1:CFG_LO_W] <= cfgHiData;
    end
  end

  // Lowest-numbered closed processor wins each module column.
  always_comb begin
    grantC    = '0;
    conflictC = '0;
    for (int m = 0; m < NUM_MEM; m++) begin
      logic taken;
      int   hits;
      taken = 1'b0;
      hits  = 0;
      for (int p = 0; p < NUM_PROC; p++) begin
        if (selQ[p*NUM_MEM+m]) begin
          grantC[p*NUM_MEM+m] = !taken;
          taken = 1'b1;
          hits  = hits + 1;
        end
      end
      conflictC[m] = (hits > 1);
    end
  end

  assign route.sel      = selQ;
  assign route.grant    = grantC;
  assign route.conflict = conflictC;

  // R1
  rst_open_chk: assert property (@(posedge clk) !rstN |=> route.sel == '0);
  // R2
  lo_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoWe |=> route.sel[CFG_LO_W-1:0] == $past(cfgLoData));
  // R2
  hi_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgHiWe |=> route.sel[SEL_W-1:CFG_LO_W] == $past(cfgHiData));
  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgLoWe && !cfgHiWe) |=> $stable(route.sel));
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import xbar_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  route_t                     route,
  input  logic [NUM_PROC*ADDR_W-1:0] procAddr,
  input  logic [NUM_PROC-1:0]        procRd,
  input  logic [NUM_PROC-1:0]        procWr,
  input  logic [NUM_PROC*DATA_W-1:0] procWrData,
  output logic [NUM_PROC*DATA_W-1:0] procRdData,
  output logic [NUM_MEM*ADDR_W-1:0]  memAddr,
  output logic [NUM_MEM-1:0]         memRd,
  output logic [NUM_MEM-1:0]         memWr,
  output logic [NUM_MEM*DATA_W-1:0]  memWrData,
  input  logic [NUM_MEM*DATA_W-1:0]  memRdData
);
  for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
    logic [NUM_PROC-1:0] colGrant;
    logic [NUM_PROC-1:0] colSel;
    logic [ADDR_W-1:0]   muxAddr;
    logic [DATA_W-1:0]   muxData;
    logic                muxRd;
    logic                muxWr;

    for (genvar p = 0; p < NUM_PROC; p++) begin : g_col
      assign colGrant[p] = route.grant[p*NUM_MEM+m];
      assign colSel[p]   = route.sel[p*NUM_MEM+m];
    end

    always_comb begin
      muxAddr = '0;
      muxData = '0;
      muxRd   = 1'b0;
      muxWr   = 1'b0;
      for (int p = 0; p < NUM_PROC; p++) begin
        if (colGrant[p]) begin
          muxAddr = muxAddr | procAddr[p*ADDR_W +: ADDR_W];
          muxData = muxData | procWrData[p*DATA_W +: DATA_W];
          muxRd   = muxRd | procRd[p];
          muxWr   = muxWr | procWr[p];
        end
      end
    end

    assign memAddr[m*ADDR_W +: ADDR_W]   = muxAddr;
    assign memWrData[m*DATA_W +: DATA_W] = muxData;
    assign memRd[m] = muxRd;
    assign memWr[m] = muxWr;

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (colSel == '0) |-> (!memRd[m] && !memWr[m] && memAddr[m*ADDR_W +: ADDR_W] == '0));
    // R6
    one_driver_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(colGrant));
    // R6
    conflict_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      route.conflict[m] |-> ($countones(colSel) >= 2));

    for (genvar p = 0; p < NUM_PROC; p++) begin : g_fan
      // R5
      write_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
        (colGrant[p] && procWr[p]) |-> memWr[m]);
    end
  end

  for (genvar p = 0; p < NUM_PROC; p++) begin : g_proc
    logic [DATA_W-1:0]  andData;
    logic [NUM_MEM-1:0] rowGrant;

    for (genvar m = 0; m < NUM_MEM; m++) begin : g_row
      assign rowGrant[m] = route.grant[p*NUM_MEM+m];
    end

    always_comb begin
      andData = '1;
      for (int m = 0; m < NUM_MEM; m++) begin
        if (rowGrant[m]) andData = andData & memRdData[m*DATA_W +: DATA_W];
      end
    end

    assign procRdData[p*DATA_W +: DATA_W] = andData;

    // R7
    float_high_chk: assert property (@(posedge clk) disable iff (!rstN)
      (rowGrant == '0) |-> (procRdData[p*DATA_W +: DATA_W] == '1));
  end
endmodule

// File: rtl/xbar_matrix.sv
module xbar_matrix
  import xbar_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgLoWe,
  input  logic [CFG_LO_W-1:0]        cfgLoData,
  input  logic                       cfgHiWe,
  input  logic [CFG_HI_W-1:0]        cfgHiData,
  input  logic [NUM_PROC*ADDR_W-1:0] procAddr,
  input  logic [NUM_PROC-1:0]        procRd,
  input  logic [NUM_PROC-1:0]        procWr,
  input  logic [NUM_PROC*DATA_W-1:0] procWrData,
  output logic [NUM_PROC*DATA_W-1:0] procRdData,
  output logic [NUM_MEM*ADDR_W-1:0]  memAddr,
  output logic [NUM_MEM-1:0]         memRd,
  output logic [NUM_MEM-1:0]         memWr,
  output logic [NUM_MEM*DATA_W-1:0]  memWrData,
  input  logic [NUM_MEM*DATA_W-1:0]  memRdData,
  output logic [NUM_MEM-1:0]         memConflict
);
  route_t route;

  xbar_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgLoWe   (cfgLoWe),
    .cfgLoData (cfgLoData),
    .cfgHiWe   (cfgHiWe),
    .cfgHiData (cfgHiData),
    .route     (route)
  );

  xbar_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .route      (route),
    .procAddr   (procAddr),
    .procRd     (procRd),
    .procWr     (procWr),
    .procWrData (procWrData),
    .procRdData (procRdData),
    .memAddr    (memAddr),
    .memRd      (memRd),
    .memWr      (memWr),
    .memWrData  (memWrData),
    .memRdData  (memRdData)
  );

  assign memConflict = route.conflict;
endmodule

// File: tb/xbar_matrix_bench.sv
`timescale 1ns/1ps
module xbar_matrix_bench;
  localparam int NP = 3;
  localparam int NM = 3;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoWe = 1'b0;
  logic [7:0] cfgLoData = '0;
  logic cfgHiWe = 1'b0;
  logic [0:0] cfgHiData = '0;
  logic [NP*AW-1:0] procAddr = '0;
  logic [NP-1:0] procRd = '0;
  logic [NP-1:0] procWr = '0;
  logic [NP*DW-1:0] procWrData = '0;
  logic [NP*DW-1:0] procRdData;
  logic [NM*AW-1:0] memAddr;
  logic [NM-1:0] memRd;
  logic [NM-1:0] memWr;
  logic [NM*DW-1:0] memWrData;
  logic [NM*DW-1:0] memRdData = '0;
  logic [NM-1:0] memConflict;

  int errors = 0;
  int checks = 0;
  logic [8:0] mSel = '0;

  logic [NM*AW-1:0] eAddr;
  logic [NM-1:0] eRd, eWr, eConf;
  logic [NM*DW-1:0] eWd;
  logic [NP*DW-1:0] eRdData;

  always #5 clk = ~clk;

  xbar_matrix u_xbar_matrix (
    .clk(clk), .rstN(rstN),
    .cfgLoWe(cfgLoWe), .cfgLoData(cfgLoData),
    .cfgHiWe(cfgHiWe), .cfgHiData(cfgHiData),
    .procAddr(procAddr), .procRd(procRd), .procWr(procWr),
    .procWrData(procWrData), .procRdData(procRdData),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWrData(memWrData), .memRdData(memRdData),
    .memConflict(memConflict)
  );

  task automatic checkVal(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic computeExp();
    eAddr = '0; eRd = '0; eWr = '0; eWd = '0; eConf = '0; eRdData = '1;
    for (int m = 0; m < NM; m++) begin
      int cnt;
      int win;
      cnt = 0;
      win = -1;
      for (int p = 0; p < NP; p++) begin
        if (mSel[p*NM+m]) begin
          cnt++;
          if (win < 0) win = p;
        end
      end
      eConf[m] = (cnt > 1);
      if (win >= 0) begin
        eAddr[m*AW +: AW] = procAddr[win*AW +: AW];
        eRd[m] = procRd[win];
        eWr[m] = procWr[win];
        eWd[m*DW +: DW] = procWrData[win*DW +: DW];
        eRdData[win*DW +: DW] = eRdData[win*DW +: DW] & memRdData[m*DW +: DW];
      end
    end
  endtask

  task automatic checkAll(string req);
    computeExp();
    checkVal(req, "memAddr", 64'(memAddr), 64'(eAddr));
    checkVal(req, "memRd", 64'(memRd), 64'(eRd));
    checkVal(req, "memWr", 64'(memWr), 64'(eWr));
    checkVal(req, "memWrData", 64'(memWrData), 64'(eWd));
    checkVal(req, "procRdData", 64'(procRdData), 64'(eRdData));
    checkVal(req, "memConflict", 64'(memConflict), 64'(eConf));
  endtask

  task automatic cfgWrite(bit doLo, logic [7:0] lo, bit doHi, bit hi);
    @(negedge clk);
    cfgLoWe = doLo; cfgLoData = lo;
    cfgHiWe = doHi; cfgHiData = hi;
    @(negedge clk);
    cfgLoWe = 1'b0; cfgHiWe = 1'b0;
    if (doLo) mSel[7:0] = lo;
    if (doHi) mSel[8] = hi;
  endtask

  task automatic randInputs();
    procAddr = {$urandom(), $urandom()};
    procRd = 3'($urandom());
    procWr = 3'($urandom());
    procWrData = 24'($urandom());
    memRdData = 24'($urandom());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    randInputs();
    repeat (3) @(negedge clk);
    // R1: reset state with busy processors
    procRd = '1; procWr = '1;
    #1;
    checkAll("R1");
    checkVal("R1", "procRdData all ones", 64'(procRdData), 64'hFF_FFFF);
    @(negedge clk); rstN = 1'b1;

    // R2: high bit alone closes p2->m2 only
    cfgWrite(0, 8'h00, 1, 1'b1);
    randInputs(); #1;
    checkAll("R2");
    checkVal("R2", "m2 address from p2", 64'(memAddr[2*AW +: AW]), 64'(procAddr[2*AW +: AW]));

    // R2: low write keeps bit 8, R8 one-to-one identity
    cfgWrite(1, 8'h11, 0, 1'b0);
    randInputs(); procRd = 3'b101; procWr = 3'b010; #1;
    checkAll("R8");
    checkVal("R3", "m1 write from p1", 64'(memWr), 64'h2);
    checkVal("R2", "bit 8 kept p2 path", 64'(memAddr[2*AW +: AW]), 64'(procAddr[2*AW +: AW]));

    // R3/R8: rotated permutation p0->m1 (bit1), p1->m2 (bit5), p2->m0 (bit6)
    cfgWrite(1, 8'h62, 1, 1'b0);
    randInputs(); #1;
    checkAll("R3");
    checkVal("R8", "m0 data from p2", 64'(memWrData[0 +: DW]), 64'(procWrData[2*DW +: DW]));

    // R5/R4: p0 fans out to all modules
    cfgWrite(1, 8'h07, 0, 1'b0);
    randInputs(); procWr = 3'b001; #1;
    checkAll("R5");
    checkVal("R5", "write copied to all", 64'(memWr), 64'h7);

    // R4: only p1->m0 (bit3), modules 1 and 2 idle
    cfgWrite(1, 8'h08, 0, 1'b0);
    randInputs(); procRd = '1; procWr = '1; #1;
    checkAll("R4");
    checkVal("R4", "idle modules quiet", 64'({memAddr[2*AW-1:AW], memAddr[3*AW-1:2*AW]}), 64'h0);

    // R6: all processors onto m0 (bits 0,3,6)
    cfgWrite(1, 8'h49, 0, 1'b0);
    randInputs(); #1;
    checkAll("R6");
    checkVal("R6", "conflict m0", 64'(memConflict), 64'h1);
    checkVal("R6", "p0 wins m0", 64'(memAddr[0 +: AW]), 64'(procAddr[0 +: AW]));
    checkVal("R7", "losers read FF", 64'(procRdData[2*DW-1:DW]), 64'hFF);

    // R7: p0 on m0 and m1, wired-AND
    cfgWrite(1, 8'h03, 0, 1'b0);
    memRdData = 24'hAA_3C_F0; #1;
    checkVal("R7", "AND of two modules", 64'(procRdData[0 +: DW]), 64'h30);
    checkVal("R7", "unconnected p2 FF", 64'(procRdData[2*DW +: DW]), 64'hFF);
    checkAll("R7");

    // R2: hold without write enables
    repeat (3) @(negedge clk);
    randInputs(); #1;
    checkAll("R2");

    // Random settings and traffic
    for (int i = 0; i < 400; i++) begin
      int mode;
      mode = int'($urandom_range(0, 2));
      cfgWrite(mode != 2, 8'($urandom()), mode != 1, 1'($urandom()));
      for (int j = 0; j < 3; j++) begin
        randInputs(); #1;
        checkAll("R6");
        @(negedge clk);
      end
    end

    // R1: reset again returns to open state
    rstN = 1'b0; mSel = '0; #1;
    checkAll("R1");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule